// File: doc/BRIEF.md
# Trace Resynchronization Scheduler

This block tells a trace encoder when to insert a synchronization packet into its output stream. While the encoder runs and tracing is active, an internal interval counter advances on a selectable event. The event is either every clock cycle or every packet the encoder reports as emitted. When the count reaches a programmable threshold, the block raises a one-cycle sync request and starts the interval again.

The block also tracks whether the encoder is running. A start trigger sets the encoder running and forces a sync. A lost packet stops the encoder. If automatic restart is enabled, the block then waits until the trace FIFO reports empty, resumes the encoder and forces a sync. With automatic restart disabled, a stopped encoder waits for the next start trigger. Every forced or periodic sync clears the interval counter.

Top module: `trace_resync_sched`

## Requirements
- R1: After reset, `sync_req_o` and `enc_running_o` are 0, the encoder is idle and the interval count is 0.
- R2: A cycle with `start_i` high makes `enc_running_o` 1 and `sync_req_o` 1 in the next cycle, and clears the interval count. `sync_req_o` drops again one cycle later unless another sync cause occurs.
- R3: With `cfg_count_pkts_i` = 0, the count rises by one in every cycle in which the encoder runs and `trace_active_i` is 1. In a running, active cycle where the count has reached the effective threshold T, `sync_req_o` is 1 in the next cycle and the count returns to 0. Undisturbed periodic requests are therefore T+1 cycles apart.
- R4: With `cfg_count_pkts_i` = 1, the count rises only in running, active cycles with `pkt_emit_i` high. The threshold comparison itself needs no emit strobe.
- R5: While `trace_active_i` is 0 or the encoder is not running, the count holds and no periodic request is made.
- R6: `pkt_lost_i` in a running cycle without `start_i` drops `enc_running_o` in the next cycle. No periodic request is issued for that cycle, even if the threshold was reached.
- R7: Once stopped by a loss, with `cfg_auto_restart_i` = 1, the first cycle with `fifo_empty_i` high gives `enc_running_o` = 1 and `sync_req_o` = 1 in the next cycle, with the count cleared.
- R8: With `cfg_auto_restart_i` = 0, a stopped encoder stays stopped whatever `fifo_empty_i` does, until `start_i`.
- R9: A threshold of 0 acts as 1, so `sync_req_o` is never high in two back-to-back cycles from periodic counting alone.
- R10: `start_i` takes priority over `pkt_lost_i` in the same cycle, and the encoder keeps running with a forced sync.
- R11: `pkt_lost_i` while the encoder is idle has no effect: `enc_running_o` and `sync_req_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval_i | input | CNT_W (24) | Sync interval threshold (0 acts as 1) |
| cfg_count_pkts_i | input | 1 | 0: count cycles, 1: count emitted packets |
| cfg_auto_restart_i | input | 1 | Resume automatically after a loss once the FIFO is empty |
| start_i | input | 1 | Start trigger strobe |
| pkt_emit_i | input | 1 | Encoder emitted a packet this cycle |
| pkt_lost_i | input | 1 | Encoder lost a packet this cycle |
| fifo_empty_i | input | 1 | Trace FIFO is empty |
| trace_active_i | input | 1 | Tracing is active |
| sync_req_o | output | 1 | One-cycle sync packet request |
| enc_running_o | output | 1 | Encoder running status |

## Verification
The interesting collisions are a periodic threshold hit in the same cycle as a packet loss, and a start trigger in the same cycle as a loss. The first must stop the encoder without a request. The second must keep it running with a forced sync. Random stimulus with small thresholds and frequent loss strobes makes both coincidences common. Directed sequences then place a loss exactly on the hit cycle and a start exactly on a loss. A cycle-level reference model in the bench judges both outputs every cycle.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    ENC_IDLE = 2'd0,
    ENC_RUN  = 2'd1,
    ENC_LOST = 2'd2
  } enc_state_e;
endpackage

// File: rtl/trs_event_sel.sv
module trs_event_sel (
  input  logic running_i,
  input  logic active_i,
  input  logic count_pkts_i,
  input  logic emit_i,
  input  logic lost_i,
  output logic eval_o,
  output logic adv_o
);
  logic evt;

  always_comb begin
    evt    = count_pkts_i ? emit_i : 1'b1;
    eval_o = running_i & active_i & ~lost_i;
    adv_o  = eval_o & evt;
  end
endmodule

// File: rtl/trs_interval_cnt.sv
module trs_interval_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             eval_i,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, thr_eff;
  logic             cnt_en;

  always_comb begin
    thr_eff = (thr_i == '0) ? ONE : thr_i;
    hit_o   = eval_i & (cnt_q >= thr_eff);
    cnt_en  = clr_i | (adv_i & ~hit_o);
    cnt_d   = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: count holds when neither advancing nor clearing
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
  // R3: a clear always lands at zero
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/trs_run_ctrl.sv
module trs_run_ctrl
  import trs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic lost_i,
  input  logic fifo_empty_i,
  input  logic auto_restart_i,
  input  logic hit_i,
  output logic running_o,
  output logic sync_set_o,
  output logic sync_o
);
  enc_state_e st_q, st_d;
  logic       sync_q;
  logic       restart;

  always_comb begin
    st_d       = st_q;
    restart    = (st_q == ENC_LOST) & auto_restart_i & fifo_empty_i;
    sync_set_o = 1'b0;
    if (start_i) begin
      st_d       = ENC_RUN;
      sync_set_o = 1'b1;
    end else begin
      unique case (st_q)
        ENC_RUN: begin
          if (lost_i)     st_d = ENC_LOST;
          else if (hit_i) sync_set_o = 1'b1;
        end
        ENC_LOST: begin
          if (restart) begin
            st_d       = ENC_RUN;
            sync_set_o = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENC_IDLE;
      sync_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sync_q <= sync_set_o;
    end
  end

  assign running_o = (st_q == ENC_RUN);
  assign sync_o    = sync_q;

  assert_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (running_o && sync_o));
  assert_lost_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && lost_i && !start_i) |=> (!running_o && !sync_o));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENC_LOST && auto_restart_i && fifo_empty_i) |=> (running_o && sync_o));
  assert_no_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENC_LOST && !auto_restart_i && !start_i) |=> !running_o);
  assert_idle_lost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENC_IDLE && !start_i) |=> (!running_o && !sync_o));
endmodule

// File: rtl/trace_resync_sched.sv
module trace_resync_sched #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_interval_i,
  input  logic             cfg_count_pkts_i,
  input  logic             cfg_auto_restart_i,
  input  logic             start_i,
  input  logic             pkt_emit_i,
  input  logic             pkt_lost_i,
  input  logic             fifo_empty_i,
  input  logic             trace_active_i,
  output logic             sync_req_o,
  output logic             enc_running_o
);
  logic running, eval, adv, hit, sync_set, sync;

  trs_event_sel u_evt (
    .running_i    (running),
    .active_i     (trace_active_i),
    .count_pkts_i (cfg_count_pkts_i),
    .emit_i       (pkt_emit_i),
    .lost_i       (pkt_lost_i),
    .eval_o       (eval),
    .adv_o        (adv)
  );

  trs_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .thr_i (cfg_interval_i),
    .eval_i(eval),
    .adv_i (adv),
    .clr_i (sync_set),
    .hit_o (hit)
  );

  trs_run_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .lost_i         (pkt_lost_i),
    .fifo_empty_i   (fifo_empty_i),
    .auto_restart_i (cfg_auto_restart_i),
    .hit_i          (hit),
    .running_o      (running),
    .sync_set_o     (sync_set),
    .sync_o         (sync)
  );

  assign sync_req_o    = sync;
  assign enc_running_o = running;

  // R9: periodic requests never back-to-back
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req_o && !start_i) |=> !sync_req_o);
endmodule

// File: tb/trace_resync_sched_tb.sv
module trace_resync_sched_tb;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] thr = 24'd128;
  logic mode = 1'b0, autor = 1'b1, start = 1'b0, emit = 1'b0, lost = 1'b0;
  logic fempty = 1'b0, active = 1'b0;
  logic sync_req, running;

  int compared = 0, mismatched = 0;
  int m_st = 0;        // 0 idle, 1 run, 2 lost
  int unsigned m_cnt = 0;
  bit m_sync = 0;

  always #4 clk = ~clk;

  trace_resync_sched #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_interval_i(thr), .cfg_count_pkts_i(mode),
    .cfg_auto_restart_i(autor), .start_i(start), .pkt_emit_i(emit),
    .pkt_lost_i(lost), .fifo_empty_i(fempty), .trace_active_i(active),
    .sync_req_o(sync_req), .enc_running_o(running)
  );

  function automatic int unsigned eff_thr(input logic [CW-1:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  task automatic model_edge();
    bit ns = 0;
    if (start) begin
      m_st = 1; m_cnt = 0; ns = 1;
    end else if (m_st == 1) begin
      if (lost) m_st = 2;
      else if (active && m_cnt >= eff_thr(thr)) begin m_cnt = 0; ns = 1; end
      else if (active && (!mode || emit)) m_cnt++;
    end else if (m_st == 2) begin
      if (autor && fempty) begin m_st = 1; m_cnt = 0; ns = 1; end
    end
    m_sync = ns;
  endtask

  task automatic check(input string tag, input logic act, input bit exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    check(tag, sync_req, m_sync, "sync_req");
    check(tag, running, (m_st == 1), "enc_running");
  endtask

  task automatic idle_in();
    start = 0; emit = 0; lost = 0;
  endtask

  initial begin
    #1600000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", sync_req, 0, "sync_req"); check("R1", running, 0, "enc_running");
    rst_n = 1;
    // R11: loss while idle ignored
    active = 1; lost = 1; step("R11"); step("R11"); idle_in(); step("R11");
    // R2: start forces sync
    thr = 3; start = 1; step("R2"); start = 0; step("R2");
    // R3: cycle counting, period T+1
    for (int i = 0; i < 12; i++) step("R3");
    // R5: inactive holds count
    active = 0; for (int i = 0; i < 6; i++) step("R5");
    active = 1; for (int i = 0; i < 5; i++) step("R5");
    // R4: packet counting
    mode = 1; for (int i = 0; i < 16; i++) begin emit = (i % 3 == 0); step("R4"); end
    emit = 0; mode = 0;
    // R9: threshold zero behaves as one
    thr = 0; start = 1; step("R9"); start = 0;
    for (int i = 0; i < 8; i++) step("R9");
    // R6: loss on the hit cycle, then R8 with restart disabled
    thr = 2; start = 1; step("R6"); start = 0; step("R6"); step("R6");
    lost = 1; step("R6"); lost = 0;
    autor = 0; fempty = 1; for (int i = 0; i < 5; i++) step("R8");
    start = 1; step("R8"); start = 0; step("R8");
    // R7: auto restart waits for empty FIFO
    autor = 1; fempty = 0; lost = 1; step("R7"); lost = 0;
    for (int i = 0; i < 4; i++) step("R7");
    fempty = 1; step("R7"); step("R7"); step("R7");
    // R10: start and loss together
    lost = 1; start = 1; step("R10"); idle_in(); step("R10");
    // random mix covering R3 R4 R6 R7 R10
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) begin
        mode  = $urandom_range(0, 1);
        autor = $urandom_range(0, 1);
        thr   = $urandom_range(0, 6);
      end
      active = ($urandom_range(0, 9) != 0);
      emit   = $urandom_range(0, 1);
      lost   = ($urandom_range(0, 29) == 0);
      fempty = ($urandom_range(0, 2) == 0);
      start  = ($urandom_range(0, 49) == 0);
      step("R3R4R6R7");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule